// File: doc/BRIEF.md
# Serial Flash Fast Read Engine

This block is the device end of a serial memory link that answers one command: a fast read. A host lowers chip select and clocks in an 8-bit opcode, a 24-bit start address and one dummy byte on the data input line. The block then streams memory bytes back on the data output line until chip select rises. Input bits are taken on rising edges of the serial clock and output bits change on falling edges. Both are sent most significant bit first.

The engine runs on a fast system clock. It synchronises the serial clock, chip select and data input and finds their edges. For each output byte it issues a one-cycle read to a synchronous byte memory outside the block and steps the read address after every byte. When the address passes the top of the array it returns to zero, so one command can sweep the whole memory any number of times. A busy input shows that a write-type cycle is in progress. When busy is high at opcode decode, the command is refused and the memory is not touched.

Top module: `sfr_fast_read`

## Requirements
- R1: After reset `spi_miso_oe` and `mem_rd_en` are low.
- R2: While chip select is low, the first 8 bits taken on rising serial clock edges form the opcode, MSB first. The fast read opcode is 8'h0B. The next 24 bits form the start address, MSB first, and the 8 bits after that are a dummy byte that is ignored.
- R3: Data bits leave on `spi_miso` MSB first and change only while the serial clock is low. The first data bit is valid after the first falling edge that follows the 8th dummy bit.
- R4: Each output byte comes from exactly one single-cycle `mem_rd_en` pulse. The first read uses the start address and each later read uses the previous address plus one.
- R5: The read after the highest address (all ones) is at address zero, and streaming continues.
- R6: Raising chip select at any bit position ends the command. `spi_miso_oe` is low within 3 system clock cycles of the rise.
- R7: An opcode other than 8'h0B leaves `spi_miso_oe` and `mem_rd_en` low for the rest of the transaction. The next transaction is decoded normally.
- R8: If `wr_busy` is high when the 8th opcode bit is taken, the command is refused: no memory read occurs and `spi_miso_oe` stays low until chip select rises.
- R9: `spi_miso_oe` is low during the opcode, address and dummy phases. It rises only after a memory read has been issued in the current transaction.
- R10: A transaction cut short inside the address leaves no state behind. The next transaction reads from its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means tri-stated |
| wr_busy | input | 1 | High while a program, erase or write cycle runs |
| mem_rd_en | output | 1 | Single-cycle memory read request |
| mem_addr | output | ADDR_W | Read address, valid with `mem_rd_en` |
| mem_rdata | input | 8 | Read data, returned one cycle after `mem_rd_en` |

## Verification
Valid reads use random start addresses and burst lengths of one to five bytes. These separate the address decode and per-byte stepping from a design that repeats one byte or misorders bits. A directed read starting two bytes below the top of the array can only pass if the address returns to zero. A wrong opcode and a busy-at-decode read are compared against the memory read count and the output enable, which tells refusal apart from silent reading. Chip select is raised mid-address and mid-data-byte, and the read that follows each abort must return data from its own address.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_DROP
  } sfr_state_e;

  localparam logic [7:0] FAST_READ_OPCODE = 8'h0B;
  localparam int         DUMMY_BITS       = 8;
endpackage

// File: rtl/sfr_rst_sync.sv
module sfr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_q <= 2'b00;
    end else begin
      stg_q <= {stg_q[0], 1'b1};
    end
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q[0] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
    end
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[g] <= RST_VAL;
        end else begin
          stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       shift,
  output logic       miso,
  output logic       oe,
  output logic       byte_done
);
  logic [7:0] sr_q, sr_d;
  logic [2:0] idx_q, idx_d;
  logic       miso_q, miso_d;
  logic       oe_q, oe_d;

  always_comb begin
    sr_d   = sr_q;
    idx_d  = idx_q;
    miso_d = miso_q;
    oe_d   = oe_q;
    if (clear) begin
      idx_d = 3'd0;
      oe_d  = 1'b0;
    end else if (shift) begin
      miso_d = sr_q[7];
      sr_d   = {sr_q[6:0], 1'b0};
      idx_d  = idx_q + 3'd1;
      oe_d   = 1'b1;
    end
    if (load) begin
      sr_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= 8'h00;
      idx_q  <= 3'd0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      idx_q  <= idx_d;
      miso_q <= miso_d;
      oe_q   <= oe_d;
    end
  end

  assign miso      = miso_q;
  assign oe        = oe_q;
  assign byte_done = (idx_q == 3'd7);
endmodule

// File: rtl/sfr_fast_read.sv
module sfr_fast_read #(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              wr_busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  import sfr_pkg::*;

  localparam int CNT_MAX = (ADDR_W > DUMMY_BITS) ? ADDR_W : DUMMY_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX);

  logic core_rst_n;
  logic sclk_s, cs_n_s, mosi_s;
  logic sclk_q;
  logic rise, fall, cs_act;

  sfr_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  sh_q, sh_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               rd_q, rd_d;
  logic               ld_q;
  logic               tx_clear, tx_shift, tx_done;
  logic [7:0]         cmd_byte;

  sfr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(core_rst_n)
  );

  sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(core_rst_n),
    .d    ({spi_sclk, spi_cs_n, spi_mosi}),
    .q    ({sclk_s, cs_n_s, mosi_s})
  );

  // Edge finder on the synchronised serial clock.
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
    end
  end

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign cs_act   = ~cs_n_s;
  assign sh_d     = {sh_q[ADDR_W-2:0], mosi_s};
  assign cmd_byte = sh_d[7:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    rd_d    = 1'b0;
    if (!cs_act) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_CMD;
          cnt_d   = '0;
        end
        ST_CMD: if (rise) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(7)) begin
            cnt_d   = '0;
            state_d = (cmd_byte == FAST_READ_OPCODE && !wr_busy) ? ST_ADDR : ST_DROP;
          end
        end
        ST_ADDR: if (rise) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_W-1)) begin
            cnt_d   = '0;
            addr_d  = sh_d;
            state_d = ST_DUMMY;
          end
        end
        ST_DUMMY: if (rise) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DUMMY_BITS-1)) begin
            cnt_d   = '0;
            rd_d    = 1'b1;
            state_d = ST_DATA;
          end
        end
        ST_DATA: if (fall && tx_done) begin
          addr_d = addr_q + 1'b1;
          rd_d   = 1'b1;
        end
        ST_DROP: state_d = ST_DROP;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (rise) begin
        sh_q <= sh_d;
      end
      addr_q <= addr_d;
      rd_q   <= rd_d;
      ld_q   <= rd_q;
    end
  end

  assign tx_clear = !cs_act || (state_q != ST_DATA);
  assign tx_shift = fall && (state_q == ST_DATA);

  sfr_tx u_tx (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clear    (tx_clear),
    .load     (ld_q),
    .load_data(mem_rdata),
    .shift    (tx_shift),
    .miso     (spi_miso),
    .oe       (spi_miso_oe),
    .byte_done(tx_done)
  );

  assign mem_rd_en = rd_q;
  assign mem_addr  = addr_q;
endmodule

// File: rtl/sfr_fast_read_chk.sv
module sfr_fast_read_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              wr_busy,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [2:0]        cs_hi_cnt;
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;
  logic              busy_all;
  logic              sess_end;

  assign sess_end = (cs_hi_cnt == 3'd3) && spi_cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi_cnt <= 3'd0;
      have_prev <= 1'b0;
      prev_addr <= '0;
      busy_all  <= 1'b1;
    end else begin
      if (!spi_cs_n) begin
        cs_hi_cnt <= 3'd0;
      end else if (cs_hi_cnt != 3'd4) begin
        cs_hi_cnt <= cs_hi_cnt + 3'd1;
      end
      if (sess_end) begin
        have_prev <= 1'b0;
        busy_all  <= 1'b1;
      end else begin
        if (mem_rd_en) begin
          have_prev <= 1'b1;
          prev_addr <= mem_addr;
        end
        if (!wr_busy) begin
          busy_all <= 1'b0;
        end
      end
    end
  end

  AST_OE_OFF_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R6

  AST_MISO_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> !spi_sclk); // R3

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && have_prev) |-> (mem_addr == prev_addr + 1'b1)); // R5

  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !busy_all); // R8

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> have_prev); // R9
endmodule

bind sfr_fast_read sfr_fast_read_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_sclk   (spi_sclk),
  .spi_cs_n   (spi_cs_n),
  .spi_miso   (spi_miso),
  .spi_miso_oe(spi_miso_oe),
  .wr_busy    (wr_busy),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr)
);

// File: tb/sfr_fast_read_test.sv
module sfr_fast_read_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;
  localparam int ADDR_W     = 24;

  logic              clk;
  logic              rst_n;
  logic              spi_sclk;
  logic              spi_cs_n;
  logic              spi_mosi;
  logic              spi_miso;
  logic              spi_miso_oe;
  logic              wr_busy;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rdata;

  int checks;
  int failures;
  int rd_count;
  bit done;

  sfr_fast_read #(.ADDR_W(ADDR_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .spi_miso_oe(spi_miso_oe),
    .wr_busy    (wr_busy),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37 + 8'd11;
    return t ^ a[15:8] ^ a[23:16];
  endfunction

  // Synchronous byte memory harness.
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem_byte(mem_addr);
      rd_count  <= rd_count + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits,
                      output logic [7:0] rx, output bit oe_all, output bit oe_any);
    rx = 8'h00;
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[7-i];
      #(HALF);
      rx[7-i] = spi_miso;
      if (spi_miso_oe !== 1'b1) oe_all = 1'b0;
      if (spi_miso_oe === 1'b1) oe_any = 1'b1;
      spi_sclk = 1'b1;
      #(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic cs_high_check(input string req);
    spi_cs_n = 1'b1;
    #(4 * CLK_PERIOD);
    check(spi_miso_oe == 1'b0, req, spi_miso_oe, 0);
    #(HALF * 2);
  endtask

  // Full read; good=0 expects refusal.
  task automatic run_read(input logic [7:0] op, input logic [ADDR_W-1:0] a,
                          input int nbytes, input bit good, input string req);
    logic [7:0] rx;
    bit         oe_all, oe_any, hdr_oe;
    int         rd0;
    rd0 = rd_count;
    hdr_oe = 1'b0;
    cs_low();
    xfer(op, 8, rx, oe_all, oe_any);          hdr_oe |= oe_any;
    xfer(a[23:16], 8, rx, oe_all, oe_any);    hdr_oe |= oe_any;
    xfer(a[15:8], 8, rx, oe_all, oe_any);     hdr_oe |= oe_any;
    xfer(a[7:0], 8, rx, oe_all, oe_any);      hdr_oe |= oe_any;
    xfer(8'hA5, 8, rx, oe_all, oe_any);       hdr_oe |= oe_any;
    check(hdr_oe == 1'b0, "R9 oe low in header", hdr_oe, 0);
    for (int b = 0; b < nbytes; b++) begin
      xfer(8'h00, 8, rx, oe_all, oe_any);
      if (good) begin
        check(rx == mem_byte(a + ADDR_W'(b)), {req, " R2 R3 R4 data"}, rx, mem_byte(a + ADDR_W'(b)));
        check(oe_all, {req, " R3 oe during data"}, oe_all, 1);
      end else begin
        check(!oe_any, {req, " oe stays low"}, oe_any, 0);
      end
    end
    if (good) check(rd_count - rd0 >= nbytes, {req, " R4 read count"}, rd_count - rd0, nbytes);
    else      check(rd_count == rd0, {req, " no memory read"}, rd_count - rd0, 0);
    cs_high_check("R6 oe off after cs high");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    bit         oe_all, oe_any;
    int unsigned seed_init;
    seed_init = $urandom(32'h5eed1234);
    checks = 0; failures = 0; rd_count = 0; done = 1'b0;
    mem_rdata = 8'h00;
    rst_n = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0; wr_busy = 1'b0;
    repeat (5) @(negedge clk);
    check(spi_miso_oe == 1'b0, "R1 oe at reset", spi_miso_oe, 0);
    check(mem_rd_en == 1'b0, "R1 rd_en at reset", mem_rd_en, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(spi_miso_oe == 1'b0 && mem_rd_en == 1'b0, "R1 idle after reset", {spi_miso_oe, mem_rd_en}, 0);

    // Directed cases.
    run_read(8'h0B, 24'h000000, 3, 1'b1, "R2 base");
    run_read(8'h0B, 24'hFFFFFE, 4, 1'b1, "R5 wrap");
    run_read(8'h03, 24'h001234, 2, 1'b0, "R7 bad opcode");
    run_read(8'h0B, 24'h00ABCD, 2, 1'b1, "R7 recovery");
    wr_busy = 1'b1;
    run_read(8'h0B, 24'h000040, 2, 1'b0, "R8 busy");
    wr_busy = 1'b0;
    run_read(8'h0B, 24'h000041, 1, 1'b1, "R8 after busy");

    // Abort inside the address (R10).
    cs_low();
    xfer(8'h0B, 8, rx, oe_all, oe_any);
    xfer(8'h77, 8, rx, oe_all, oe_any);
    xfer(8'h66, 5, rx, oe_all, oe_any);
    cs_high_check("R10 abort in address");
    run_read(8'h0B, 24'h5A0010, 2, 1'b1, "R10 fresh read");

    // Abort inside a data byte (R6).
    cs_low();
    xfer(8'h0B, 8, rx, oe_all, oe_any);
    xfer(8'h12, 8, rx, oe_all, oe_any);
    xfer(8'h34, 8, rx, oe_all, oe_any);
    xfer(8'h56, 8, rx, oe_all, oe_any);
    xfer(8'h00, 8, rx, oe_all, oe_any);
    xfer(8'h00, 3, rx, oe_all, oe_any);
    check(rx[7:5] == mem_byte(24'h123456) >> 5, "R6 partial byte", rx[7:5], mem_byte(24'h123456) >> 5);
    cs_high_check("R6 abort in data");

    // Random reads.
    for (int n = 0; n < 16; n++) begin
      logic [ADDR_W-1:0] a;
      int len;
      a   = ADDR_W'($urandom);
      if (n % 4 == 3) a = 24'hFFFFFF - ADDR_W'($urandom_range(0, 3));
      len = $urandom_range(1, 5);
      run_read(8'h0B, a, len, 1'b1, "R4 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule